// File: doc/BRIEF.md
# ADC Conversion Result Store with Pair-Packing FIFO

This block holds the 16-bit results of an analog-to-digital converter in twelve result slots and offers them to a processor or a DMA engine. It has two modes, chosen by a single enable input. In direct mode, each result lands in the slot that the conversion's memory-control index names. That slot's result flag rises, and the slot is read back by index. In FIFO mode, the index is ignored. Results fill the slots in arrival order, and the only way to consume them is a 32-bit packed port that always delivers two samples at once.

Each slot has a result flag. Software or a DMA engine can use the flags as thresholds. In FIFO mode, using the flag of an odd slot keeps every packed read aligned to a sample pair. Two single-cycle pulses report misuse. The overflow pulse means a result overwrote a slot whose value was never consumed. The underflow pulse means data was read before it existed. The exact conditions for each pulse depend on the mode.

Top module: `adc_result_store`

## Requirements
- R1: After reset, every result flag is 0, every slot holds 0, the packed word is 0, and both the overflow and underflow pulses are 0.
- R2: In direct mode, a write with index x in the range 0 to 11 stores the data in slot x and sets flag bit x on the next clock edge. The read data output always shows the slot named by the read index, combinationally.
- R3: In direct mode, a slot read clears that slot's flag. A read of a slot whose flag is 0 raises the underflow pulse in the following cycle.
- R4: In direct mode, a write to a slot whose flag is already set raises the overflow pulse in the following cycle. The exception is a read of the same slot in the same cycle, which consumes the old value; in that case there is no overflow and the flag stays set.
- R5: In FIFO mode, each write goes to the slot at the write pointer regardless of its index and sets that slot's flag. The pointer steps 0, 1, …, 11 and then wraps to 0.
- R6: In FIFO mode, a packed read succeeds when the two slots at the even read pointer p and at p+1 both have their flags set. On the next edge, the packed word becomes {slot p+1 in bits 31:16, slot p in bits 15:0}, both flags clear, and p advances by two, wrapping from 10 to 0.
- R7: In FIFO mode, a packed read when the pair is incomplete raises the underflow pulse. It changes no flag, no pointer and no packed word.
- R8: The packed word is not cleared by reading it. It changes only on a successful packed read.
- R9: In FIFO mode, a write to a slot whose flag is still set raises the overflow pulse, unless a successful packed read consumes that slot in the same cycle.
- R10: In FIFO mode, the slot read strobe has no effect on flags or underflow. In direct mode, the packed read strobe has no effect.
- R11: While FIFO mode is off, both pointers are held at 0, so the first write after FIFO mode is enabled lands in slot 0.
- R12: In direct mode, writes with index 12 to 15 are ignored. Reads with those indices return 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects direct mode |
| wr_stb | input | 1 | Conversion result write strobe |
| wr_idx | input | 4 | Memory-control index of the result (direct mode) |
| wr_data | input | 16 | Conversion result |
| rd_stb | input | 1 | Slot read strobe (direct mode) |
| rd_idx | input | 4 | Slot selected for reading |
| pk_rd_stb | input | 1 | Packed pair read strobe (FIFO mode) |
| rd_data | output | 16 | Contents of the slot named by rd_idx |
| pk_data | output | 32 | Packed pair word, older sample in the low half |
| res_flag | output | 12 | Per-slot result flags |
| ovf | output | 1 | Overflow pulse, one cycle |
| unf | output | 1 | Underflow pulse, one cycle |

## Verification
The assertions check the following on every cycle:
- A flag rises only after a write, and a direct-mode write always leaves its flag set.
- An overflow or underflow pulse always traces back to a write or to a read that is legal in the current mode.
- The packed word changes only after a packed read in FIFO mode.
- A packed read clears either no flags or exactly two.
- A slot read in FIFO mode changes nothing.

Only the bench's scenarios can show that:
- the data values land in the right slots;
- the halves of a packed word appear in the right order;
- the pointers wrap and restart correctly;
- a read in the same cycle suppresses overflow.

The bench shows these by comparing every output against an arithmetic model across sweeps of all indices and long mixed write-and-read streams.

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int SLOTS = 12,
  parameter int DW    = 16,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic            wr_stb,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_stb,
  input  logic [IW-1:0]   rd_idx,
  input  logic            pk_rd_stb,
  output logic [DW-1:0]   rd_data,
  output logic [2*DW-1:0] pk_data,
  output logic [SLOTS-1:0] res_flag,
  output logic            ovf,
  output logic            unf
);
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] flag_q;
  logic [IW-1:0]    wp_q, rp_q;

  wire rd_ok   = 32'(rd_idx) < SLOTS;
  wire wr_ok   = 32'(wr_idx) < SLOTS;
  wire dir_rd  = !fifo_en && rd_stb && rd_ok;
  wire dir_wr  = !fifo_en && wr_stb && wr_ok;

  wire [IW-1:0] rp1  = rp_q + 1'b1;
  wire pair_ok       = flag_q[rp_q] & flag_q[rp1];
  wire pk_take       = fifo_en && pk_rd_stb && pair_ok;

  wire          do_wr = fifo_en ? wr_stb : dir_wr;
  wire [IW-1:0] wslot = fifo_en ? wp_q : wr_idx;

  logic [SLOTS-1:0] clr_m, set_m;
  always_comb begin
    clr_m = '0;
    if (dir_rd)  clr_m = SLOTS'(1) << rd_idx;
    if (pk_take) clr_m = (SLOTS'(1) << rp_q) | (SLOTS'(1) << rp1);
    set_m = do_wr ? (SLOTS'(1) << wslot) : '0;
  end

  wire ovf_d = do_wr && flag_q[wslot] && !clr_m[wslot];
  wire unf_d = (dir_rd && !flag_q[rd_idx]) || (fifo_en && pk_rd_stb && !pair_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
      flag_q  <= '0;
      wp_q    <= '0;
      rp_q    <= '0;
      pk_data <= '0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else begin
      if (do_wr) slot_q[wslot] <= wr_data;
      flag_q <= (flag_q & ~clr_m) | set_m;
      if (pk_take) pk_data <= {slot_q[rp1], slot_q[rp_q]};
      if (!fifo_en) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (wr_stb)  wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
        if (pk_take) rp_q <= (rp1 == LAST) ? '0 : rp1 + 1'b1;
      end
      ovf <= ovf_d;
      unf <= unf_d;
    end
  end

  assign rd_data  = rd_ok ? slot_q[rd_idx] : '0;
  assign res_flag = flag_q;
endmodule

module adc_result_store_chk #(
  parameter int SLOTS = 12,
  localparam int IW   = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             wr_stb,
  input logic [IW-1:0]    wr_idx,
  input logic             rd_stb,
  input logic             pk_rd_stb,
  input logic [31:0]      pk_data,
  input logic [SLOTS-1:0] res_flag,
  input logic             ovf,
  input logic             unf
);
  assert_flag_rise_R2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |(res_flag & ~$past(res_flag)) |-> $past(wr_stb));

  assert_direct_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && wr_stb && 32'(wr_idx) < SLOTS) |=> res_flag[$past(wr_idx)]);

  assert_no_overflow_R4_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(wr_stb));

  assert_unf_cause_R3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> $past((rd_stb && !fifo_en) || (pk_rd_stb && fifo_en)));

  assert_pk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_data != $past(pk_data)) |-> $past(pk_rd_stb && fifo_en));

  assert_pair_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && pk_rd_stb && !wr_stb) |=>
      ($countones(res_flag) == $countones($past(res_flag))) ||
      ($countones(res_flag) + 2 == $countones($past(res_flag))));

  assert_slot_rd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rd_stb && !wr_stb && !pk_rd_stb) |=>
      (res_flag == $past(res_flag)) && !unf);
endmodule

bind adc_result_store adc_result_store_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/adc_result_store_test.sv
`timescale 1ns/1ps
module adc_result_store_test;
  logic clk = 1'b0, rst_n = 1'b0, fifo_en = 1'b0;
  logic wr_stb = 1'b0, rd_stb = 1'b0, pk_rd_stb = 1'b0;
  logic [3:0] wr_idx = '0, rd_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [31:0] pk_data;
  logic [11:0] res_flag;
  logic ovf, unf;

  int n_chk = 0, n_bad = 0;

  logic [15:0] ms [12];
  logic [11:0] mf = '0;
  logic [31:0] mpk = '0;
  int mwp = 0, mrp = 0;

  always #2.5 clk = ~clk;

  adc_result_store uut (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic w, input logic [3:0] wi, input logic [15:0] wd,
                     input logic r, input logic [3:0] ri, input logic p);
    logic [15:0] ns [12];
    logic [11:0] nf;
    logic [31:0] npk;
    logic e_ovf, e_unf, rh, wh, av, cons;
    int nwp, nrp;
    wr_stb = w; wr_idx = wi; wr_data = wd; rd_stb = r; rd_idx = ri; pk_rd_stb = p;
    ns = ms; nf = mf; npk = mpk; nwp = mwp; nrp = mrp; e_ovf = 0; e_unf = 0;
    #1;
    chk(tag, "rd_data", 32'(rd_data), (ri < 12) ? 32'(ms[ri]) : 32'h0);
    if (!fifo_en) begin
      rh = r && (ri < 12);
      wh = w && (wi < 12);
      e_unf = rh && !mf[ri];
      e_ovf = wh && mf[wi] && !(rh && ri == wi);
      if (rh) nf[ri] = 1'b0;
      if (wh) begin ns[wi] = wd; nf[wi] = 1'b1; end
      nwp = 0; nrp = 0;
    end else begin
      av = mf[mrp] && mf[mrp+1];
      cons = p && av;
      e_unf = p && !av;
      if (cons) begin
        npk = {ms[mrp+1], ms[mrp]};
        nf[mrp] = 1'b0; nf[mrp+1] = 1'b0;
        nrp = (mrp + 2) % 12;
      end
      e_ovf = w && mf[mwp] && !(cons && (mwp == mrp || mwp == mrp + 1));
      if (w) begin ns[mwp] = wd; nf[mwp] = 1'b1; nwp = (mwp + 1) % 12; end
    end
    @(posedge clk); #1;
    ms = ns; mf = nf; mpk = npk; mwp = nwp; mrp = nrp;
    chk(tag, "res_flag", 32'(res_flag), 32'(mf));
    chk(tag, "pk_data", pk_data, mpk);
    chk(tag, "ovf", 32'(ovf), 32'(e_ovf));
    chk(tag, "unf", 32'(unf), 32'(e_unf));
    wr_stb = 0; rd_stb = 0; pk_rd_stb = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) ms[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1", "res_flag", 32'(res_flag), 0);
    chk("R1", "pk_data", pk_data, 0);
    chk("R1", "ovf", 32'(ovf), 0);
    chk("R1", "unf", 32'(unf), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);

    // R2 / R12: direct writes over every index value
    for (int i = 0; i < 16; i++)
      cyc(i < 12 ? "R2" : "R12", 1, 4'(i), 16'hA000 + 16'(i * 37), 0, 0, 0);
    // R3: reads clear flags; R12 out-of-range reads give 0
    for (int i = 0; i < 16; i++)
      cyc(i < 12 ? "R3" : "R12", 0, 0, 0, 1, 4'(i), 0);
    for (int i = 0; i < 12; i++)
      cyc("R3", 0, 0, 0, 1, 4'(i), 0);
    // R4 overflow and same-cycle read exception
    cyc("R4", 1, 5, 16'h1111, 0, 0, 0);
    cyc("R4", 1, 5, 16'h2222, 0, 5, 0);
    cyc("R4", 1, 5, 16'h3333, 1, 5, 0);
    cyc("R4", 1, 7, 16'h4444, 1, 5, 0);
    // R10: packed strobe in direct mode
    cyc("R10", 0, 0, 0, 0, 5, 1);
    cyc("R10", 0, 0, 0, 1, 5, 1);
    cyc("R3", 0, 0, 0, 1, 7, 0);

    // FIFO mode
    fifo_en = 1'b1;
    cyc("R7", 0, 0, 0, 0, 0, 1);
    cyc("R5", 1, 9, 16'hBEEF, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 1);
    cyc("R5", 1, 3, 16'hCAFE, 0, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 40; n++)
      cyc("R5", 1, 4'(n % 16), 16'h5000 + 16'(n * 101), 0, 4'(n % 12), (n % 3) == 0);
    for (int n = 0; n < 8; n++)
      cyc("R6", 0, 0, 0, 0, 4'(n), 1);
    // R9: thirteen writes with no reads must overflow
    for (int n = 0; n < 13; n++)
      cyc("R9", 1, 0, 16'h7000 + 16'(n), 0, 4'(n % 12), 0);
    // R10: slot reads in FIFO mode change nothing
    for (int i = 0; i < 12; i++)
      cyc("R10", 0, 0, 0, 1, 4'(i), 0);
    for (int n = 0; n < 7; n++)
      cyc("R6", 1, 0, 16'h9000 + 16'(n), 0, 0, 1);
    // R11: leaving FIFO mode restarts the pointers
    fifo_en = 1'b0;
    cyc("R11", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++)
      cyc("R11", 0, 0, 0, 1, 4'(i), 0);
    fifo_en = 1'b1;
    cyc("R11", 1, 6, 16'hD00D, 0, 0, 0);
    cyc("R11", 1, 6, 16'hD11D, 0, 1, 0);
    cyc("R11", 0, 0, 0, 0, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule